// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the operand shifter of a processor datapath. It takes one 32-bit operand, a 3-bit shift-kind code, an 8-bit shift amount and the current carry flag. It returns the shifted value, the carry that the shift produces, and a flag that says whether the carry flag should be written. It is purely combinational and holds no state.

The shift amount may come from an immediate field or from the low byte of a register. Every amount from 0 to 255 therefore has a defined result. Amounts of 32 and above follow fixed rules for each kind: logical shifts saturate to zero, arithmetic shifts saturate to the sign, and rotates wrap around.

A single log-depth rotator serves every kind. Left shifts are formed by rotating right by the complement of the amount. A mask then clears or sign-fills the vacated bits. Classification of the amount selects between the normal path and the saturated results.

Top module: `barrel_shift_unit`

## Requirements
- R1: Logical right shift (kind code 1) by n from 1 to 31 gives operand >> n with zeros in the upper bits and carry_out = operand[n-1], with carry_update = 1.
- R2: Logical left shift (kind code 0) by n from 1 to 31 gives operand << n with zeros in the lower bits and carry_out = operand[32-n], with carry_update = 1.
- R3: Arithmetic right shift (kind code 2) by n from 1 to 31 fills the upper n bits with operand[31] and gives carry_out = operand[n-1], with carry_update = 1.
- R4: A logical shift by exactly 32 gives a zero result with carry_update = 1. The carry_out is operand[0] for a left shift and operand[31] for a right shift.
- R5: A logical shift left or right by 33 to 255 gives a zero result, carry_out = 0 and carry_update = 1.
- R6: An arithmetic right shift by 32 to 255 sets every result bit to operand[31], sets carry_out = operand[31], and sets carry_update = 1.
- R7: Rotate right (kind code 3) by an amount whose value mod 32 is r, with r not 0, rotates the operand by r places, sets carry_out to result bit 31, and sets carry_update = 1. The amount is 8 bits wide, 0 to 255.
- R8: Rotate right by a nonzero multiple of 32 (32, 64 and so on up to 224) returns the operand unchanged with carry_out = operand[31] and carry_update = 1.
- R9: Rotate right with extend (kind code 4) ignores the amount. It gives {carry_in, operand[31:1]}, carry_out = operand[0] and carry_update = 1.
- R10: An amount of 0 for kind codes 0 to 3 passes the operand through unchanged, with carry_out = carry_in and carry_update = 0.
- R11: Kind codes 5 to 7 are unused. They pass the operand through with carry_out = carry_in and carry_update = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_kind | input | 3 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate with extend |
| shift_amount | input | 8 | Shift distance, 0 to 255 |
| operand | input | 32 | Value to shift |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted value |
| carry_out | output | 1 | Carry produced by the shift, or carry_in when no update |
| carry_update | output | 1 | High when the carry flag should take carry_out |

## Verification
All three outputs depend only on the present inputs, so each result is due in the same cycle its stimulus is applied, with no register on the path. The bench applies each vector on a falling clock edge and samples the outputs a quarter period later, well before the next rising edge. Stimulus covers every kind code and every amount from 0 to 255, with directed and random operands under both carry values.

// File: rtl/barrel_shift_pkg.sv
package barrel_shift_pkg;
    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;
endpackage

// File: rtl/shift_amount_classify.sv
module shift_amount_classify #(
    parameter int W     = 32,
    parameter int AMT_W = 8,
    localparam int SH_W = $clog2(W)
) (
    input  logic [AMT_W-1:0] amount,
    output logic             is_zero,
    output logic             is_full,
    output logic             is_over,
    output logic [SH_W-1:0]  low_amt,
    output logic [SH_W-1:0]  neg_amt
);
    always_comb begin
        is_zero = (amount == '0);
        is_full = (int'(amount) == W);
        is_over = (int'(amount) > W);
        low_amt = amount[SH_W-1:0];
        neg_amt = SH_W'(0) - amount[SH_W-1:0];
    end
endmodule

// File: rtl/shift_rotator.sv
module shift_rotator #(
    parameter int W = 32,
    localparam int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] rot,
    output logic [W-1:0]    dout
);
    logic [W-1:0] stage [SH_W+1];

    assign stage[0] = din;

    for (genvar g = 0; g < SH_W; g++) begin : g_stage
        localparam int D = 1 << g;
        assign stage[g+1] = rot[g] ? {stage[g][D-1:0], stage[g][W-1:D]} : stage[g];
    end

    assign dout = stage[SH_W];
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
    import barrel_shift_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input  logic [2:0]       shift_kind,
    input  logic [AMT_W-1:0] shift_amount,
    input  logic [W-1:0]     operand,
    input  logic             carry_in,
    output logic [W-1:0]     result,
    output logic             carry_out,
    output logic             carry_update
);
    localparam int SH_W = $clog2(W);
    localparam logic [W-1:0] ONES = {W{1'b1}};

    shift_kind_e     kind_e;
    logic            is_zero, is_full, is_over;
    logic [SH_W-1:0] low_amt, neg_amt, rot_sel;
    logic [W-1:0]    rot_out, mask_r, mask_l, sign_fill;

    assign kind_e = shift_kind_e'(shift_kind);

    shift_amount_classify #(.W(W), .AMT_W(AMT_W)) u_classify (
        .amount  (shift_amount),
        .is_zero (is_zero),
        .is_full (is_full),
        .is_over (is_over),
        .low_amt (low_amt),
        .neg_amt (neg_amt)
    );

    assign rot_sel = (kind_e == SK_LSL) ? neg_amt : low_amt;

    shift_rotator #(.W(W)) u_rotator (
        .din  (operand),
        .rot  (rot_sel),
        .dout (rot_out)
    );

    assign mask_r    = ONES >> low_amt;
    assign mask_l    = ONES << low_amt;
    assign sign_fill = {W{operand[W-1]}};

    always_comb begin
        result       = operand;
        carry_out    = carry_in;
        carry_update = 1'b0;
        unique case (kind_e)
            SK_LSL: begin
                if (!is_zero) begin
                    carry_update = 1'b1;
                    if (is_over) begin
                        result    = '0;
                        carry_out = 1'b0;
                    end else if (is_full) begin
                        result    = '0;
                        carry_out = operand[0];
                    end else begin
                        result    = rot_out & mask_l;
                        carry_out = operand[neg_amt];
                    end
                end
            end
            SK_LSR: begin
                if (!is_zero) begin
                    carry_update = 1'b1;
                    if (is_over) begin
                        result    = '0;
                        carry_out = 1'b0;
                    end else if (is_full) begin
                        result    = '0;
                        carry_out = operand[W-1];
                    end else begin
                        result    = rot_out & mask_r;
                        carry_out = operand[low_amt - SH_W'(1)];
                    end
                end
            end
            SK_ASR: begin
                if (!is_zero) begin
                    carry_update = 1'b1;
                    if (is_over || is_full) begin
                        result    = sign_fill;
                        carry_out = operand[W-1];
                    end else begin
                        result    = (rot_out & mask_r) | (sign_fill & ~mask_r);
                        carry_out = operand[low_amt - SH_W'(1)];
                    end
                end
            end
            SK_ROR: begin
                if (!is_zero) begin
                    carry_update = 1'b1;
                    result       = rot_out;
                    carry_out    = rot_out[W-1];
                end
            end
            SK_RRX: begin
                carry_update = 1'b1;
                result       = {carry_in, operand[W-1:1]};
                carry_out    = operand[0];
            end
            default: begin
                result       = operand;
                carry_out    = carry_in;
                carry_update = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/barrel_shift_checks.sv
module barrel_shift_checks #(
    parameter int W     = 32,
    parameter int AMT_W = 8
) (
    input logic [2:0]       shift_kind,
    input logic [AMT_W-1:0] shift_amount,
    input logic [W-1:0]     operand,
    input logic             carry_in,
    input logic [W-1:0]     result,
    input logic             carry_out,
    input logic             carry_update
);
    always_comb begin
        if (shift_kind <= 3'd3 && shift_amount == '0) begin
            p_zero_pass_r10: assert (result == operand && carry_out == carry_in && !carry_update);
        end
        if (shift_kind >= 3'd5) begin
            p_unused_code_r11: assert (result == operand && carry_out == carry_in && !carry_update);
        end
        if (shift_kind == 3'd4) begin
            p_rrx_r9: assert (result == {carry_in, operand[W-1:1]} && carry_out == operand[0] && carry_update);
        end
        if (shift_kind <= 3'd1 && int'(shift_amount) > W) begin
            p_logic_over_r5: assert (result == '0 && !carry_out && carry_update);
        end
        if (shift_kind == 3'd2 && int'(shift_amount) >= W) begin
            p_asr_sat_r6: assert (result == {W{operand[W-1]}} && carry_out == operand[W-1]);
        end
        if (shift_kind == 3'd3 && shift_amount != '0 && (int'(shift_amount) % W) == 0) begin
            p_ror_whole_r8: assert (result == operand && carry_out == operand[W-1] && carry_update);
        end
        if (shift_kind == 3'd3 && shift_amount != '0) begin
            p_ror_carry_r7: assert (carry_out == result[W-1] && $countones(result) == $countones(operand));
        end
    end
endmodule

bind barrel_shift_unit barrel_shift_checks #(.W(W), .AMT_W(AMT_W)) u_checks (
    .shift_kind   (shift_kind),
    .shift_amount (shift_amount),
    .operand      (operand),
    .carry_in     (carry_in),
    .result       (result),
    .carry_out    (carry_out),
    .carry_update (carry_update)
);

// File: tb/barrel_shift_unit_bench.sv
module barrel_shift_unit_bench;
    logic        clk = 1'b0;
    logic [2:0]  shift_kind = '0;
    logic [7:0]  shift_amount = '0;
    logic [31:0] operand = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_out;
    logic        carry_update;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    barrel_shift_unit u_barrel_shift_unit (
        .shift_kind   (shift_kind),
        .shift_amount (shift_amount),
        .operand      (operand),
        .carry_in     (carry_in),
        .result       (result),
        .carry_out    (carry_out),
        .carry_update (carry_update)
    );

    function automatic logic [33:0] ref_shift(logic [2:0] k, logic [7:0] n, logic [31:0] a, logic c);
        int i;
        int r;
        logic [31:0] rr;
        i = int'(n);
        case (k)
            3'd0: begin
                if (i == 0)       return {1'b0, c, a};
                else if (i > 32)  return {1'b1, 1'b0, 32'h0};
                else if (i == 32) return {1'b1, a[0], 32'h0};
                else              return {1'b1, a[32-i], a << i};
            end
            3'd1: begin
                if (i == 0)       return {1'b0, c, a};
                else if (i > 32)  return {1'b1, 1'b0, 32'h0};
                else if (i == 32) return {1'b1, a[31], 32'h0};
                else              return {1'b1, a[i-1], a >> i};
            end
            3'd2: begin
                if (i == 0)       return {1'b0, c, a};
                else if (i >= 32) return {1'b1, a[31], {32{a[31]}}};
                else              return {1'b1, a[i-1], 32'($signed(a) >>> i)};
            end
            3'd3: begin
                if (i == 0) return {1'b0, c, a};
                r = i % 32;
                if (r == 0) return {1'b1, a[31], a};
                rr = (a >> r) | (a << (32 - r));
                return {1'b1, rr[31], rr};
            end
            3'd4:    return {1'b1, a[0], {c, a[31:1]}};
            default: return {1'b0, c, a};
        endcase
    endfunction

    function automatic string req_tag(logic [2:0] k, logic [7:0] n);
        int i;
        i = int'(n);
        case (k)
            3'd0: return (i == 0) ? "R10" : (i < 32) ? "R2" : (i == 32) ? "R4" : "R5";
            3'd1: return (i == 0) ? "R10" : (i < 32) ? "R1" : (i == 32) ? "R4" : "R5";
            3'd2: return (i == 0) ? "R10" : (i < 32) ? "R3" : "R6";
            3'd3: return (i == 0) ? "R10" : ((i % 32) == 0) ? "R8" : "R7";
            3'd4: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic apply_and_check(logic [2:0] k, logic [7:0] n, logic [31:0] a, logic c);
        logic [33:0] exp_v;
        logic [33:0] got_v;
        @(negedge clk);
        shift_kind   = k;
        shift_amount = n;
        operand      = a;
        carry_in     = c;
        #5;
        exp_v = ref_shift(k, n, a, c);
        got_v = {carry_update, carry_out, result};
        checks++;
        if (got_v !== exp_v) begin
            errors++;
            $display("FAIL %s kind=%0d amt=%0d op=%h cin=%0b: actual upd=%0b c=%0b res=%h expected upd=%0b c=%0b res=%h",
                     req_tag(k, n), k, n, a, c, got_v[33], got_v[32], got_v[31:0],
                     exp_v[33], exp_v[32], exp_v[31:0]);
        end
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : stimulus
        logic [31:0] ops [3];
        void'($urandom(32'd1234));
        // All-zero inputs at start: zero shift of zero operand, R10
        apply_and_check(3'd0, 8'd0, 32'h0, 1'b0);
        // Directed corners: R4 at exactly 32, R9 extend, R8 whole rotations
        apply_and_check(3'd0, 8'd32, 32'h0000_0001, 1'b0);
        apply_and_check(3'd1, 8'd32, 32'h8000_0000, 1'b0);
        apply_and_check(3'd4, 8'd200, 32'h0000_0003, 1'b1);
        apply_and_check(3'd3, 8'd64, 32'h8000_0001, 1'b0);
        for (int k = 0; k < 8; k++) begin
            for (int n = 0; n < 256; n++) begin
                ops[0] = (n % 2 == 0) ? 32'h8000_0001 : 32'h7FFF_FFFE;
                ops[1] = $urandom;
                ops[2] = $urandom;
                for (int o = 0; o < 3; o++) begin
                    for (int c = 0; c < 2; c++) begin
                        apply_and_check(3'(k), 8'(n), ops[o], 1'(c));
                    end
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule